// File: doc/BRIEF.md
# Bidirectional GPIO Port with Peripheral Override

This block is an 8-bit general-purpose I/O port that a processor reaches through three memory-mapped registers: a direction register, an output latch, and a pin register that returns the sampled pad levels. Each pin can be an input or an output on its own. When a pin is an output, the pad driver carries the latch value. When it is an input, the driver is released to high impedance.

Every pin also has a peripheral path. While a pin's peripheral select is high, the peripheral's data replaces the latch value on the pad. The peripheral's enable then decides the driver state for that pin, in either direction. The stored direction bits stay as software wrote them, so read-modify-write of the direction register is never disturbed by an override. Pad levels pass through a two-flop synchronizer. The synchronized value feeds both the pin register read and the peripheral input lines.

Top module: `gpio_port_ovr`

## Requirements
- R1: While reset is active and after it, the direction register reads 0xFF, the output latch reads 0x00 and every pad_oe bit is 0.
- R2: For a pin without peripheral select, a direction bit of 0 gives pad_oe=1 with pad_out equal to the latch bit. A direction bit of 1 gives pad_oe=0.
- R3: The address map is 0 for direction, 1 for pin and 2 for latch. A write to address 1 or to address 2 loads the output latch on the rising clock edge. A write to address 0 loads the direction register.
- R4: A read of address 2 returns the latch contents whatever the pad levels are.
- R5: A read of address 1 returns pad_in through two flops. A change appears after the second rising edge and not after the first.
- R6: While per_sel[i] is 1, pad_out[i] equals per_out[i].
- R7: While per_sel[i] is 1, pad_oe[i] equals per_oe[i], and the direction bit has no effect. While per_sel[i] is 0, per_oe[i] has no effect.
- R8: An override never changes the direction register. The value read back from address 0 stays as it was written.
- R9: per_in always carries the synchronized pad level, whatever the select and direction bits are.
- R10: Writing 0xCF to the direction register with no selects active gives pad_oe = 0x30.
- R11: Address 3 reads as 0x00, and a write to it changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on address |
| per_sel | input | 8 | Per-pin peripheral select |
| per_out | input | 8 | Per-pin peripheral output data |
| per_oe | input | 8 | Per-pin peripheral driver enable (1 = drive) |
| per_in | output | 8 | Synchronized pad level to peripherals |
| pad_in | input | 8 | Pad input level |
| pad_out | output | 8 | Pad output value |
| pad_oe | output | 8 | Pad driver enable (1 = drive) |

## Verification
The direction, latch and select paths are tried with several pattern sets: all outputs, all inputs, a split half, the 0xCF setting, and mixed override masks. In the override cases, per_oe both forces a pin to output and forces it to input, and some of those pins have the opposite stored direction. These patterns separate a correct per-pin multiplexer from one that ignores select, swaps the data and enable sources, or lets per_oe act on pins that are not selected. Pad inputs are checked one edge and two edges after a change, which confirms the depth of the synchronizer. Writes to every address, each followed by readbacks, show that the latch is loaded from two addresses and that the unused address has no effect.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int PORT_W = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_DIR  = 2'd0,
        REG_PIN  = 2'd1,
        REG_LAT  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = gpio_port_pkg::PORT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] stage1;
        logic [W-1:0] stage2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.stage1 = raw_in;
        st_d.stage2 = st_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.stage2;
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int W  = PORT_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [W-1:0]  wdata,
    input  logic [W-1:0]  pin_level,
    output logic [W-1:0]  rdata,
    output logic [W-1:0]  dir_q,
    output logic [W-1:0]  lat_q
);
    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] lat;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            case (addr)
                REG_DIR:          st_d.dir = wdata;
                REG_PIN, REG_LAT: st_d.lat = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.dir <= '1;
            st_q.lat <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (addr)
            REG_DIR: rdata = st_q.dir;
            REG_PIN: rdata = pin_level;
            REG_LAT: rdata = st_q.lat;
            default: rdata = '0;
        endcase
    end

    assign dir_q = st_q.dir;
    assign lat_q = st_q.lat;
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
    parameter int W = gpio_port_pkg::PORT_W
) (
    input  logic [W-1:0] dir_bits,
    input  logic [W-1:0] lat_bits,
    input  logic [W-1:0] sel,
    input  logic [W-1:0] alt_out,
    input  logic [W-1:0] alt_oe,
    output logic [W-1:0] drv_val,
    output logic [W-1:0] drv_en
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        always_comb begin
            if (sel[i]) begin
                drv_val[i] = alt_out[i];
                drv_en[i]  = alt_oe[i];
            end else begin
                drv_val[i] = lat_bits[i];
                drv_en[i]  = ~dir_bits[i];
            end
        end
    end
endmodule

// File: rtl/gpio_port_ovr.sv
module gpio_port_ovr
    import gpio_port_pkg::*;
#(
    parameter int W  = PORT_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    input  logic [W-1:0]  per_sel,
    input  logic [W-1:0]  per_out,
    input  logic [W-1:0]  per_oe,
    output logic [W-1:0]  per_in,
    input  logic [W-1:0]  pad_in,
    output logic [W-1:0]  pad_out,
    output logic [W-1:0]  pad_oe
);
    logic [W-1:0] pin_sync;
    logic [W-1:0] dir_q;
    logic [W-1:0] lat_q;

    gpio_in_sync #(.W(W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (pad_in),
        .sync_out (pin_sync)
    );

    gpio_port_regs #(.W(W), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (bus_addr),
        .we        (bus_we),
        .wdata     (bus_wdata),
        .pin_level (pin_sync),
        .rdata     (bus_rdata),
        .dir_q     (dir_q),
        .lat_q     (lat_q)
    );

    gpio_pin_mux #(.W(W)) u_mux (
        .dir_bits (dir_q),
        .lat_bits (lat_q),
        .sel      (per_sel),
        .alt_out  (per_out),
        .alt_oe   (per_oe),
        .drv_val  (pad_out),
        .drv_en   (pad_oe)
    );

    assign per_in = pin_sync;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int W  = gpio_port_pkg::PORT_W,
    parameter int AW = gpio_port_pkg::ADDR_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic          bus_we,
    input logic [W-1:0]  bus_wdata,
    input logic [W-1:0]  bus_rdata,
    input logic [W-1:0]  per_sel,
    input logic [W-1:0]  per_out,
    input logic [W-1:0]  per_in,
    input logic [W-1:0]  pad_in,
    input logic [W-1:0]  pad_out,
    input logic [W-1:0]  pad_oe,
    input logic [W-1:0]  dir_q,
    input logic [W-1:0]  lat_q
);
    logic [1:0] edges_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  edges_seen <= 2'd0;
        else if (edges_seen != 2'd2) edges_seen <= edges_seen + 2'd1;
    end

    assert_latch_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_addr == 2'd1 || bus_addr == 2'd2)) |=> lat_q == $past(bus_wdata));

    assert_dir_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == 2'd0) |=> $stable(dir_q));

    assert_override_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & per_sel) == (per_out & per_sel));

    assert_plain_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~per_sel) == (~dir_q & ~per_sel));

    assert_sync_depth_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (edges_seen == 2'd2) |-> per_in == $past(pad_in, 2));

    assert_latch_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd2) |-> bus_rdata == lat_q);

    assert_spare_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd3) |-> bus_rdata == '0);
endmodule

bind gpio_port_ovr gpio_port_chk #(.W(W), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .per_sel   (per_sel),
    .per_out   (per_out),
    .per_in    (per_in),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .dir_q     (dir_q),
    .lat_q     (lat_q)
);

// File: tb/sim_gpio_port_ovr.sv
module sim_gpio_port_ovr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] per_sel = 8'h00;
    logic [7:0] per_out = 8'h00;
    logic [7:0] per_oe = 8'h00;
    logic [7:0] per_in;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    gpio_port_ovr u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .per_sel(per_sel),
        .per_out(per_out), .per_oe(per_oe), .per_in(per_in),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    typedef struct packed {
        logic [7:0] dir;
        logic [7:0] lat;
        logic [7:0] sel;
        logic [7:0] pout;
        logic [7:0] poe;
        logic [7:0] e_out;
        logic [7:0] e_oe;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 8'hA5, 8'h00, 8'h00, 8'h00, 8'hA5, 8'hFF},
        '{8'hFF, 8'h3C, 8'h00, 8'hFF, 8'hFF, 8'h3C, 8'h00},
        '{8'h0F, 8'h00, 8'hF0, 8'hFF, 8'h30, 8'hF0, 8'h30},
        '{8'hCF, 8'h55, 8'h03, 8'h02, 8'h01, 8'h56, 8'h31},
        '{8'hF0, 8'h0F, 8'h81, 8'h80, 8'h00, 8'h8E, 8'h0E}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        #4000000;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        // R1: reset values
        #25;
        bus_read(2'd0, rd); check("R1 dir during reset", rd, 8'hFF);
        check("R1 oe during reset", pad_oe, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        bus_read(2'd0, rd); check("R1 dir after reset", rd, 8'hFF);
        bus_read(2'd2, rd); check("R1 latch after reset", rd, 8'h00);
        check("R1 oe after reset", pad_oe, 8'h00);

        // table walk: R2 R6 R7 R8
        for (int k = 0; k < NV; k++) begin
            bus_write(2'd0, VECS[k].dir);
            bus_write(2'd2, VECS[k].lat);
            per_sel = VECS[k].sel; per_out = VECS[k].pout; per_oe = VECS[k].poe;
            #1;
            check("R2/R6 pad_out", pad_out, VECS[k].e_out);
            check("R2/R7 pad_oe", pad_oe, VECS[k].e_oe);
            bus_read(2'd0, rd); check("R8 dir readback under override", rd, VECS[k].dir);
        end
        per_sel = 8'h00; per_out = 8'h00; per_oe = 8'h00;

        // R10: 0xCF direction setting
        bus_write(2'd0, 8'hCF);
        #1; check("R10 oe for 0xCF", pad_oe, 8'h30);

        // R7: per_oe ignored without select
        per_oe = 8'hFF; #1;
        check("R7 per_oe ignored when unselected", pad_oe, 8'h30);
        per_oe = 8'h00;

        // R3: write via pin address loads latch
        bus_write(2'd1, 8'h9A);
        bus_read(2'd2, rd); check("R3 latch via pin address", rd, 8'h9A);
        check("R3 pad_out bits 5:4", pad_out & 8'h30, 8'h10);

        // R4 R5 R9: synchronizer depth and latch independence
        @(negedge clk); pad_in = 8'h6C;
        @(negedge clk);
        bus_read(2'd1, rd); check("R5 pin after one edge", rd, 8'h00);
        @(negedge clk);
        bus_read(2'd1, rd); check("R5 pin after two edges", rd, 8'h6C);
        check("R9 per_in", per_in, 8'h6C);
        bus_read(2'd2, rd); check("R4 latch ignores pads", rd, 8'h9A);
        per_sel = 8'hFF; per_oe = 8'hFF; #1;
        check("R9 per_in under override", per_in, 8'h6C);
        per_sel = 8'h00; per_oe = 8'h00;

        // R11: spare address
        bus_write(2'd3, 8'hFF);
        bus_read(2'd3, rd); check("R11 spare reads zero", rd, 8'h00);
        bus_read(2'd0, rd); check("R11 dir unchanged", rd, 8'hCF);
        bus_read(2'd2, rd); check("R11 latch unchanged", rd, 8'h9A);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule